// File: doc/BRIEF.md
# Per-Rank DRAM Command Timing Guard

This block watches the commands a memory controller issues to one DRAM rank and reports, every controller clock, whether each of the four command kinds (activate, read CAS, write CAS, precharge) may legally be issued at the next clock edge. It enforces five programmed minimum spacings. Activate comes before CAS, activate before precharge, precharge before activate, read CAS before precharge, and write CAS before precharge. Each spacing is counted in controller clock cycles and covers commands to this rank only.

A scheduler drives a command strobe with its type whenever it issues a command to the rank. It can also present a candidate command type and read back a single verdict for that type. All five spacings come from one packed 32-bit configuration word. The word is sampled when the constraining command issues, so changing it never alters a window that is already running.

Top module: `rank_timing_guard`

## Requirements
- R1: A clock edge with `rst_n` low clears every spacing window, and all four allow flags read 1 in the following cycle.
- R2: After an activate issues at edge E, `allow_rd` and `allow_wr` are 0 until edge E+N is the next edge, where N is configuration bits 12:9.
- R3: After an activate issues at edge E, `allow_pre` is held 0 until edge E+N is the next edge, where N is configuration bits 8:4.
- R4: After a precharge issues at edge E, `allow_act` is 0 until edge E+N is the next edge, where N is configuration bits 3:0.
- R5: After a read CAS issues at edge E, `allow_pre` is held 0 until edge E+N is the next edge, where N is configuration bits 16:13.
- R6: After a write CAS issues at edge E, `allow_pre` is held 0 until edge E+N is the next edge, where N is configuration bits 21:17.
- R7: A spacing field of 0 or 1 places no constraint, so the dependent command is allowed at the very next edge.
- R8: `allow_pre` is 1 only when the activate-to-precharge, read-to-precharge and write-to-precharge windows have all elapsed.
- R9: A spacing uses the configuration value present at the edge where its constraining command issues. A later change to `cfg_word` does not alter a window that is already running.
- R10: Command types are encoded 0 = activate, 1 = read CAS, 2 = write CAS, 3 = precharge. `cand_ok` equals the allow flag of the type on `cand_type`.
- R11: A repeated constraining command restarts its window from the later issue, using the value it was issued with.
- R12: Configuration bits 31:22 have no effect on any allow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Packed spacing configuration |
| cmd_valid | input | 1 | A command issues to the rank at this edge |
| cmd_type | input | 2 | Type of the issued command |
| cand_type | input | 2 | Candidate command type to evaluate |
| allow_act | output | 1 | Activate may issue at the next edge |
| allow_rd | output | 1 | Read CAS may issue at the next edge |
| allow_wr | output | 1 | Write CAS may issue at the next edge |
| allow_pre | output | 1 | Precharge may issue at the next edge |
| cand_ok | output | 1 | Allow flag selected by `cand_type` |

## Verification
The assertions assume that `cmd_type` and `cfg_word` are steady at each rising edge, and that a command strobe means the command really went to this rank. They do not assume that issued commands obey the allow flags: a spacing window simply restarts on every new constraining command. The stimulus drives all inputs once per cycle on the falling edge. It issues commands of random type at random times, whether or not they are allowed, and reprograms the configuration word with random field values and random upper bits.

// File: rtl/rtg_pkg.sv
// Shared types and field layout for the per-rank command timing guard.
// Assumes one rank and commands encoded as in rtg_cmd_e.
package rtg_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } rtg_cmd_e;

    // Field widths inside the configuration word
    localparam int RP_W   = 4;
    localparam int RAS_W  = 5;
    localparam int RCD_W  = 4;
    localparam int RTP_W  = 4;
    localparam int WTP_W  = 5;
    localparam int CFG_W  = 32;

    // Field positions derived from widths (packed from bit 0 upward)
    localparam int RP_LSB  = 0;
    localparam int RAS_LSB = RP_LSB + RP_W;
    localparam int RCD_LSB = RAS_LSB + RAS_W;
    localparam int RTP_LSB = RCD_LSB + RCD_W;
    localparam int WTP_LSB = RTP_LSB + RTP_W;
    localparam int USED_W  = WTP_LSB + WTP_W;

    // Counter width able to hold any field
    localparam int CNT_W = 5;
    localparam int NUM_GAPS = 5;

    // Window indices
    localparam int GAP_RP  = 0;  // precharge -> activate
    localparam int GAP_RAS = 1;  // activate  -> precharge
    localparam int GAP_RCD = 2;  // activate  -> CAS
    localparam int GAP_RTP = 3;  // read CAS  -> precharge
    localparam int GAP_WTP = 4;  // write CAS -> precharge

    typedef struct packed {
        logic [WTP_W-1:0] wtp;
        logic [RTP_W-1:0] rtp;
        logic [RCD_W-1:0] rcd;
        logic [RAS_W-1:0] ras;
        logic [RP_W-1:0]  rp;
    } rtg_cfg_t;

endpackage

// File: rtl/rtg_cfg_unpack.sv
// Splits the packed configuration word into spacing fields.
// Assumes the layout given by rtg_pkg; bits above USED_W are ignored.
module rtg_cfg_unpack
    import rtg_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output rtg_cfg_t         cfg
);

    logic [CFG_W-1:0] unused_hi;

    // Slice each field out of the word
    always_comb begin
        cfg.rp    = cfg_word[RP_LSB  +: RP_W];
        cfg.ras   = cfg_word[RAS_LSB +: RAS_W];
        cfg.rcd   = cfg_word[RCD_LSB +: RCD_W];
        cfg.rtp   = cfg_word[RTP_LSB +: RTP_W];
        cfg.wtp   = cfg_word[WTP_LSB +: WTP_W];
        unused_hi = cfg_word >> USED_W;
    end

    logic unused_ok;
    assign unused_ok = ^unused_hi;

endmodule

// File: rtl/rtg_gap_counter.sv
// One spacing window: a saturating down-counter loaded on the
// constraining command. A limit of N allows the dependent command
// N edges after the load; 0 and 1 both mean the very next edge.
// Assumes limit is steady at the loading edge.
module rtg_gap_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt;
    logic [W-1:0] start;

    // Remaining edges to wait after the loading edge
    always_comb begin
        start = (limit == '0) ? '0 : limit - W'(1);
    end

    // Load on issue, otherwise count down and hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/rank_timing_guard.sv
// Per-rank DRAM command timing guard. Tracks five same-rank spacings
// and reports, each cycle, which command types may issue at the next
// edge. Assumes cmd_valid marks a command actually sent to this rank.
module rank_timing_guard
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_type,
    input  logic [1:0]       cand_type,
    output logic             allow_act,
    output logic             allow_rd,
    output logic             allow_wr,
    output logic             allow_pre,
    output logic             cand_ok
);

    rtg_cfg_t             cfg;
    logic [CNT_W-1:0]     gap_limit [NUM_GAPS];
    logic [NUM_GAPS-1:0]  gap_load;
    logic [NUM_GAPS-1:0]  gap_done;

    rtg_cfg_unpack u_unpack (
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    // Widen each field to the common counter width
    always_comb begin
        gap_limit[GAP_RP]  = CNT_W'(cfg.rp);
        gap_limit[GAP_RAS] = CNT_W'(cfg.ras);
        gap_limit[GAP_RCD] = CNT_W'(cfg.rcd);
        gap_limit[GAP_RTP] = CNT_W'(cfg.rtp);
        gap_limit[GAP_WTP] = CNT_W'(cfg.wtp);
    end

    // Decide which windows the issued command starts
    always_comb begin
        gap_load          = '0;
        gap_load[GAP_RP]  = cmd_valid && (cmd_type == CMD_PRE);
        gap_load[GAP_RAS] = cmd_valid && (cmd_type == CMD_ACT);
        gap_load[GAP_RCD] = cmd_valid && (cmd_type == CMD_ACT);
        gap_load[GAP_RTP] = cmd_valid && (cmd_type == CMD_RD);
        gap_load[GAP_WTP] = cmd_valid && (cmd_type == CMD_WR);
    end

    for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
        rtg_gap_counter #(.W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (gap_load[g]),
            .limit   (gap_limit[g]),
            .expired (gap_done[g])
        );
    end

    // Combine windows into per-type permissions
    always_comb begin
        allow_act = gap_done[GAP_RP];
        allow_rd  = gap_done[GAP_RCD];
        allow_wr  = gap_done[GAP_RCD];
        allow_pre = gap_done[GAP_RAS] & gap_done[GAP_RTP] & gap_done[GAP_WTP];
    end

    // Select the verdict for the candidate type
    always_comb begin
        unique case (cand_type)
            CMD_ACT: cand_ok = allow_act;
            CMD_RD:  cand_ok = allow_rd;
            CMD_WR:  cand_ok = allow_wr;
            default: cand_ok = allow_pre;
        endcase
    end

endmodule

// File: rtl/rtg_chk.sv
// Checker for rank_timing_guard: relates issued commands and the
// configuration at that edge to the permissions seen one cycle later.
module rtg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_word,
    input logic        cmd_valid,
    input logic [1:0]  cmd_type,
    input logic        allow_act,
    input logic        allow_rd,
    input logic        allow_wr,
    input logic        allow_pre
);

    // R2
    rcd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd0 && cfg_word[12:9] >= 4'd2) |=> (!allow_rd && !allow_wr));

    // R3
    ras_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd0 && cfg_word[8:4] >= 5'd2) |=> !allow_pre);

    // R4
    rp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd3 && cfg_word[3:0] >= 4'd2) |=> !allow_act);

    // R5
    rtp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd1 && cfg_word[16:13] >= 4'd2) |=> !allow_pre);

    // R6
    wtp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd2 && cfg_word[21:17] >= 5'd2) |=> !allow_pre);

    // R7
    rcd_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd0 && cfg_word[12:9] <= 4'd1) |=> (allow_rd && allow_wr));

endmodule

bind rank_timing_guard rtg_chk i_rtg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .allow_act (allow_act),
    .allow_rd  (allow_rd),
    .allow_wr  (allow_wr),
    .allow_pre (allow_pre)
);

// File: tb/test_rank_timing_guard.sv
// Bench for rank_timing_guard: directed corner cases, then seeded
// random traffic, all checked against an edge-count reference model.
module test_rank_timing_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic [1:0]  cand_type = '0;
    logic        allow_act, allow_rd, allow_wr, allow_pre, cand_ok;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state: edge of last issue and value taken, per window
    int last_edge [5];
    int last_val  [5];
    int up_edge;

    always #4 clk = ~clk;  // 125 MHz

    rank_timing_guard i_rank_timing_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg_word),
        .cmd_valid (cmd_valid),
        .cmd_type  (cmd_type),
        .cand_type (cand_type),
        .allow_act (allow_act),
        .allow_rd  (allow_rd),
        .allow_wr  (allow_wr),
        .allow_pre (allow_pre),
        .cand_ok   (cand_ok)
    );

    function automatic int field(logic [31:0] w, int idx);
        case (idx)
            0:       return int'(w[3:0]);
            1:       return int'(w[8:4]);
            2:       return int'(w[12:9]);
            3:       return int'(w[16:13]);
            default: return int'(w[21:17]);
        endcase
    endfunction

    function automatic bit win_ok(int idx);
        if (last_edge[idx] < 0) return 1'b1;
        return (up_edge - last_edge[idx]) >= last_val[idx];
    endfunction

    task automatic chk(bit act, bit exp, string req, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (edge %0d)", req, what, act, exp, up_edge);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin
            last_edge[i] = -1;
            last_val[i]  = 0;
        end
        up_edge = 0;
    endtask

    // Compare all outputs against the model
    task automatic check_all();
        bit ea, er, ep, ec;
        ea = win_ok(0);
        er = win_ok(2);
        ep = win_ok(1) && win_ok(3) && win_ok(4);
        case (cand_type)
            2'd0: ec = ea;
            2'd1: ec = er;
            2'd2: ec = er;
            default: ec = ep;
        endcase
        chk(allow_act, ea, "R4", "allow_act");
        chk(allow_rd,  er, "R2", "allow_rd");
        chk(allow_wr,  er, "R2", "allow_wr");
        chk(allow_pre, ep, "R8", "allow_pre");
        chk(cand_ok,   ec, "R10", "cand_ok");
    endtask

    // Drive one edge's inputs, update model, step to next falling edge, check
    task automatic tick(bit v, logic [1:0] t, logic [1:0] c);
        cmd_valid = v;
        cmd_type  = t;
        cand_type = c;
        if (v) begin
            case (t)
                2'd0: begin
                    last_edge[1] = up_edge; last_val[1] = field(cfg_word, 1);
                    last_edge[2] = up_edge; last_val[2] = field(cfg_word, 2);
                end
                2'd1: begin last_edge[3] = up_edge; last_val[3] = field(cfg_word, 3); end
                2'd2: begin last_edge[4] = up_edge; last_val[4] = field(cfg_word, 4); end
                default: begin last_edge[0] = up_edge; last_val[0] = field(cfg_word, 0); end
            endcase
        end
        @(negedge clk);
        up_edge++;
        cmd_valid = 1'b0;
        check_all();
    endtask

    // Issue one command, then count edges until flag rises
    task automatic gap_of(logic [1:0] t, int which, output int gap);
        bit f;
        tick(1'b1, t, 2'd0);
        gap = 1;
        for (int k = 0; k < 40; k++) begin
            case (which)
                0: f = allow_act;
                1: f = allow_rd;
                default: f = allow_pre;
            endcase
            if (f) break;
            tick(1'b0, 2'd0, 2'd0);
            gap++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 2'(i));
    endtask

    function automatic logic [31:0] mk(int rp, int ras, int rcd, int rtp, int wtp);
        return {10'd0, 5'(wtp), 4'(rtp), 4'(rcd), 5'(ras), 4'(rp)};
    endfunction

    initial begin
        int g;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();

        // Load long windows, then R1: reset clears them
        cfg_word = mk(15, 31, 15, 15, 31);
        tick(1'b1, 2'd0, 2'd0);
        tick(1'b1, 2'd3, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(allow_act & allow_rd & allow_wr & allow_pre, 1'b1, "R1", "all flags after reset");
        rst_n = 1'b1;
        model_reset();

        // R2: activate-to-CAS
        cfg_word = mk(0, 0, 7, 0, 0);
        gap_of(2'd0, 1, g); chk(g == 7, 1'b1, "R2", $sformatf("rcd gap %0d exp 7", g));
        // R3: activate-to-precharge
        cfg_word = mk(0, 19, 0, 0, 0);
        gap_of(2'd0, 2, g); chk(g == 19, 1'b1, "R3", $sformatf("ras gap %0d exp 19", g));
        // R4: precharge-to-activate
        cfg_word = mk(9, 0, 0, 0, 0);
        gap_of(2'd3, 0, g); chk(g == 9, 1'b1, "R4", $sformatf("rp gap %0d exp 9", g));
        // R5: read-to-precharge
        cfg_word = mk(0, 0, 0, 13, 0);
        gap_of(2'd1, 2, g); chk(g == 13, 1'b1, "R5", $sformatf("rtp gap %0d exp 13", g));
        // R6: write-to-precharge
        cfg_word = mk(0, 0, 0, 0, 27);
        gap_of(2'd2, 2, g); chk(g == 27, 1'b1, "R6", $sformatf("wtp gap %0d exp 27", g));
        // R7: zero and one place no constraint
        cfg_word = mk(0, 1, 0, 1, 0);
        gap_of(2'd0, 2, g); chk(g == 1, 1'b1, "R7", $sformatf("zero/one gap %0d exp 1", g));
        // R8: precharge waits for the longest of three windows
        cfg_word = mk(0, 4, 0, 10, 6);
        tick(1'b1, 2'd0, 2'd3);
        tick(1'b1, 2'd2, 2'd3);
        gap_of(2'd1, 2, g); chk(g == 10, 1'b1, "R8", $sformatf("combined gap %0d exp 10", g));
        // R9: changing config mid-window does not move the window
        cfg_word = mk(12, 0, 0, 0, 0);
        tick(1'b1, 2'd3, 2'd0);
        cfg_word = mk(1, 0, 0, 0, 0);
        g = 1;
        while (!allow_act && g < 40) begin tick(1'b0, 2'd0, 2'd0); g++; end
        chk(g == 12, 1'b1, "R9", $sformatf("held gap %0d exp 12", g));
        // R11: reissue restarts the window
        cfg_word = mk(0, 0, 8, 0, 0);
        tick(1'b1, 2'd0, 2'd1);
        idle(5);
        gap_of(2'd0, 1, g); chk(g == 8, 1'b1, "R11", $sformatf("restart gap %0d exp 8", g));
        // R12: upper bits ignored
        cfg_word = mk(0, 0, 5, 0, 0) | 32'hFFC0_0000;
        gap_of(2'd0, 1, g); chk(g == 5, 1'b1, "R12", $sformatf("upper-bit gap %0d exp 5", g));

        // Random traffic, R10 and all windows checked every cycle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0)
                cfg_word = $urandom() & ($urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0003_DEF7);
            tick($urandom_range(0, 2) == 0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
        end

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule